// File: doc/BRIEF.md
# Three-Mode Timer with Reload

A 16-bit down-counter with two 16-bit companion registers. The counter has three operating modes. It can generate a PWM waveform without processor help. It can count external events. It can capture the count on input edges. The companion registers change role with the mode. In PWM mode they are the pair of alternating reload values. In event mode the first one is the reload value. In capture mode they are the two capture latches.

Software reaches the block through a byte-wide register port. The port has eight addresses and a combinational read path. The counter advances on a clock-enable pulse taken from the instruction cycle, or on edges of the count pin. Two pending flags, each gated by its own enable, drive two interrupt outputs. The count pin and the auxiliary pin are taken to be already synchronous to `clk`.

Top module: `tri_mode_timer`

## Requirements
- R1: After reset the counter, both companion registers, the control register, both pending flags, `pwm_out`, `irq_a` and `irq_b` are all zero.
- R2: The byte addresses are 0/1 for the counter low/high bytes, 2/3 for register A low/high, 4/5 for register B low/high, 6 for control and 7 for flags. Control holds mode in bits [1:0] (00 PWM, 01 event, 10 capture, 11 halted), run in bit 2, count-edge select in bit 3 (0 rising, 1 falling), enable A in bit 4 and enable B in bit 5. Bits 7:6 read as zero. Flags holds pending A in bit 0 and pending B in bit 1.
- R3: A read of address 0 returns the live low byte and also latches the high byte. A read of address 1 returns that latched byte, not the live one.
- R4: With run at 0, or with mode 11, the counter keeps its value.
- R5: In PWM mode each tick decrements the counter. A tick at count zero is an underflow. The first underflow after reset loads register B, toggles `pwm_out` and sets pending A. The next loads register A, toggles `pwm_out` and sets pending B, and so on in alternation.
- R6: In event mode the counter decrements on each selected edge of `pin_a`, and ticks have no effect. An edge at count zero reloads register A and sets pending A.
- R7: In event mode a rising edge on `pin_b` sets pending B only while enable B is 1.
- R8: In capture mode the counter decrements per tick and wraps from 0 to 0xFFFF. A selected edge on `pin_a` copies the counter into register A and sets pending A. A rising edge on `pin_b` copies it into register B and sets pending B.
- R9: Writing a flag bit as 0 clears it. Writing it as 1 leaves it unchanged. A hardware set in the same cycle as a clear leaves the flag set.
- R10: `irq_a` is pending A AND enable A. `irq_b` is pending B AND enable B.
- R11: A software write to a counter byte in the same cycle as a decrement event takes priority: the written byte is stored, the other byte keeps its value, and no underflow action happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Instruction-cycle clock enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms the high-byte latch) |
| addr | input | 3 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pin_a | input | 1 | Count / capture pin A |
| pin_b | input | 1 | Auxiliary pin B |
| pwm_out | output | 1 | PWM output, toggled on underflow |
| irq_a | output | 1 | Interrupt A |
| irq_b | output | 1 | Interrupt B |

## Verification
Two pairs of functions can land on the same edge. A hardware flag set can meet a software clear of that flag. A tick can meet a software write to the counter. The bench raises a capture edge on `pin_a` in the same cycle as a write of zero to the flags. It then reads back pending A, which must still be set. It also drives a tick together with a counter low-byte write while PWM is running. The 16-bit count read afterwards must be exactly the written value, with no extra decrement.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        MODE_PWM = 2'b00,
        MODE_EVT = 2'b01,
        MODE_CAP = 2'b10,
        MODE_OFF = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic      en_b;
        logic      en_a;
        logic      edge_fall;
        logic      run;
        tmr_mode_e mode;
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);

    localparam logic [ADDR_W-1:0] ADR_CNT_LO = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CNT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_RA_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_RA_HI  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_RB_LO  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_RB_HI  = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd6;
    localparam logic [ADDR_W-1:0] ADR_FLAGS  = 3'd7;

    // hardware requests from the counter core toward the register file
    typedef struct packed {
        logic set_pa;
        logic set_pb;
        logic cap_a;
        logic cap_b;
    } tmr_evt_t;

    function automatic logic hit(input logic en, input logic [ADDR_W-1:0] a,
                                 input logic [ADDR_W-1:0] target);
        return en && (a == target);
    endfunction

endpackage

// File: rtl/tmr_edge.sv
module tmr_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_o
);
    logic pin_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= pin;
    end

    always_comb begin
        if (fall_sel) edge_o = !pin && pin_q;
        else          edge_o = pin && !pin_q;
    end
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  tmr_evt_t          evt,
    output tmr_ctrl_t         ctrl_q,
    output logic [CNT_W-1:0]  ra_q,
    output logic [CNT_W-1:0]  rb_q,
    output logic              pend_a,
    output logic              pend_b,
    output logic              cnt_wr_lo,
    output logic              cnt_wr_hi
);
    localparam int HI_W = CNT_W - BUS_W;

    logic [HI_W-1:0] hi_lat;
    logic            flag_wr;

    assign cnt_wr_lo = hit(wr_en, addr, ADR_CNT_LO);
    assign cnt_wr_hi = hit(wr_en, addr, ADR_CNT_HI);
    assign flag_wr   = hit(wr_en, addr, ADR_FLAGS);

    always_ff @(posedge clk) begin
        if (rst) begin
            ra_q   <= '0;
            rb_q   <= '0;
            ctrl_q <= '0;
            pend_a <= 1'b0;
            pend_b <= 1'b0;
            hi_lat <= '0;
        end else begin
            // capture has priority over a software byte write
            if (evt.cap_a)                         ra_q <= cnt;
            else if (hit(wr_en, addr, ADR_RA_LO))  ra_q[BUS_W-1:0] <= wdata;
            else if (hit(wr_en, addr, ADR_RA_HI))  ra_q[CNT_W-1:BUS_W] <= wdata[HI_W-1:0];

            if (evt.cap_b)                         rb_q <= cnt;
            else if (hit(wr_en, addr, ADR_RB_LO))  rb_q[BUS_W-1:0] <= wdata;
            else if (hit(wr_en, addr, ADR_RB_HI))  rb_q[CNT_W-1:BUS_W] <= wdata[HI_W-1:0];

            if (hit(wr_en, addr, ADR_CTRL))
                ctrl_q <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);

            // write-zero-to-clear; a hardware set in the same cycle wins
            pend_a <= evt.set_pa || (pend_a && !(flag_wr && !wdata[0]));
            pend_b <= evt.set_pb || (pend_b && !(flag_wr && !wdata[1]));

            if (hit(rd_en, addr, ADR_CNT_LO))
                hi_lat <= cnt[CNT_W-1:BUS_W];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADR_CNT_LO: rdata = cnt[BUS_W-1:0];
            ADR_CNT_HI: rdata[HI_W-1:0] = hi_lat;
            ADR_RA_LO:  rdata = ra_q[BUS_W-1:0];
            ADR_RA_HI:  rdata[HI_W-1:0] = ra_q[CNT_W-1:BUS_W];
            ADR_RB_LO:  rdata = rb_q[BUS_W-1:0];
            ADR_RB_HI:  rdata[HI_W-1:0] = rb_q[CNT_W-1:BUS_W];
            ADR_CTRL:   rdata[CTRL_W-1:0] = ctrl_q;
            ADR_FLAGS:  rdata[1:0] = {pend_b, pend_a};
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_ctrl_t        ctrl,
    input  logic             tick,
    input  logic             edge_a,
    input  logic             rise_b,
    input  logic [CNT_W-1:0] ra,
    input  logic [CNT_W-1:0] rb,
    input  logic             cnt_wr_lo,
    input  logic             cnt_wr_hi,
    input  logic [BUS_W-1:0] wbyte,
    output logic [CNT_W-1:0] cnt_q,
    output logic             pwm_q,
    output tmr_evt_t         evt
);
    localparam int HI_W = CNT_W - BUS_W;

    logic phase_q;
    logic dec, cnt_wr, uflow;
    logic [CNT_W-1:0] reload;

    assign cnt_wr = cnt_wr_lo || cnt_wr_hi;

    always_comb begin
        unique case (ctrl.mode)
            MODE_PWM: dec = ctrl.run && tick;
            MODE_EVT: dec = ctrl.run && edge_a;
            MODE_CAP: dec = ctrl.run && tick;
            default:  dec = 1'b0;
        endcase
    end

    // a software counter write suppresses the decrement and any underflow action
    assign uflow  = dec && !cnt_wr && (cnt_q == '0) && (ctrl.mode != MODE_CAP);
    assign reload = (ctrl.mode == MODE_PWM && !phase_q) ? rb : ra;

    always_comb begin
        evt = '0;
        unique case (ctrl.mode)
            MODE_PWM: begin
                evt.set_pa = uflow && !phase_q;
                evt.set_pb = uflow &&  phase_q;
            end
            MODE_EVT: begin
                evt.set_pa = uflow;
                evt.set_pb = rise_b && ctrl.en_b;
            end
            MODE_CAP: begin
                evt.cap_a  = ctrl.run && edge_a;
                evt.cap_b  = ctrl.run && rise_b;
                evt.set_pa = evt.cap_a;
                evt.set_pb = evt.cap_b;
            end
            default: evt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            pwm_q   <= 1'b0;
        end else begin
            if (cnt_wr_lo)      cnt_q[BUS_W-1:0] <= wbyte;
            else if (cnt_wr_hi) cnt_q[CNT_W-1:BUS_W] <= wbyte[HI_W-1:0];
            else if (uflow)     cnt_q <= reload;
            else if (dec)       cnt_q <= cnt_q - 1'b1;

            if (uflow && ctrl.mode == MODE_PWM) begin
                phase_q <= !phase_q;
                pwm_q   <= !pwm_q;
            end
        end
    end
endmodule

// File: rtl/tri_mode_timer.sv
module tri_mode_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic              pin_a,
    input  logic              pin_b,
    output logic              pwm_out,
    output logic              irq_a,
    output logic              irq_b
);
    tmr_ctrl_t        ctrl_q;
    tmr_evt_t         evt;
    logic [CNT_W-1:0] cnt_q, ra_q, rb_q;
    logic             pend_a, pend_b, cnt_wr_lo, cnt_wr_hi;
    logic             edge_a, rise_b;

    tmr_edge u_edge_a (
        .clk(clk), .rst(rst), .pin(pin_a), .fall_sel(ctrl_q.edge_fall), .edge_o(edge_a)
    );
    tmr_edge u_edge_b (
        .clk(clk), .rst(rst), .pin(pin_b), .fall_sel(1'b0), .edge_o(rise_b)
    );

    tmr_regif #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regif (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cnt(cnt_q), .evt(evt), .ctrl_q(ctrl_q),
        .ra_q(ra_q), .rb_q(rb_q), .pend_a(pend_a), .pend_b(pend_b),
        .cnt_wr_lo(cnt_wr_lo), .cnt_wr_hi(cnt_wr_hi)
    );

    tmr_core #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_core (
        .clk(clk), .rst(rst), .ctrl(ctrl_q), .tick(tick), .edge_a(edge_a),
        .rise_b(rise_b), .ra(ra_q), .rb(rb_q), .cnt_wr_lo(cnt_wr_lo),
        .cnt_wr_hi(cnt_wr_hi), .wbyte(wdata), .cnt_q(cnt_q), .pwm_q(pwm_out),
        .evt(evt)
    );

    assign irq_a = pend_a && ctrl_q.en_a;
    assign irq_b = pend_b && ctrl_q.en_b;
endmodule

// File: rtl/tri_mode_timer_chk.sv
module tri_mode_timer_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]       wdata,
    input logic             pwm_out,
    input logic [CNT_W-1:0] cnt,
    input tmr_ctrl_t        ctrl,
    input logic             edge_a,
    input logic             pend_a,
    input logic             pend_b
);
    logic cnt_wr;
    assign cnt_wr = wr_en && (addr == ADR_CNT_LO || addr == ADR_CNT_HI);

    p_hold_stopped_r4: assert property (@(posedge clk) disable iff (rst)
        ((!ctrl.run || ctrl.mode == MODE_OFF) && !cnt_wr) |=> $stable(cnt));

    p_pwm_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_PWM && ctrl.run && tick && cnt == '0 && !cnt_wr)
        |=> (pwm_out != $past(pwm_out)));

    p_pwm_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.mode == MODE_PWM && ctrl.run && tick && cnt == '0) |=> $stable(pwm_out));

    p_evt_tick_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_EVT && !edge_a && !cnt_wr) |=> $stable(cnt));

    p_pinb_gated_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_EVT && !ctrl.en_b && !pend_b) |=> !pend_b);

    p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_CAP && ctrl.run && tick && cnt == '0 && !cnt_wr)
        |=> (cnt == {CNT_W{1'b1}}));

    p_pend_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (pend_a && !(wr_en && addr == ADR_FLAGS && !wdata[0])) |=> pend_a);
endmodule

bind tri_mode_timer tri_mode_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pwm_out(pwm_out), .cnt(cnt_q), .ctrl(ctrl_q), .edge_a(edge_a),
    .pend_a(pend_a), .pend_b(pend_b)
);

// File: tb/tri_mode_timer_tb_top.sv
module tri_mode_timer_tb_top;
    import tmr_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       pin_a = 1'b0, pin_b = 1'b0;
    logic       pwm_out, irq_a, irq_b;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tri_mode_timer dut_i (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pin_a(pin_a), .pin_b(pin_b),
        .pwm_out(pwm_out), .irq_a(irq_a), .irq_b(irq_b)
    );

    // {addr, write byte, expected read byte}: write then read back
    localparam logic [18:0] REG_VEC [0:8] = '{
        {ADR_RA_LO,  8'h34, 8'h34},
        {ADR_RA_HI,  8'h12, 8'h12},
        {ADR_RB_LO,  8'hCD, 8'hCD},
        {ADR_RB_HI,  8'hAB, 8'hAB},
        {ADR_CTRL,   8'h38, 8'h38},
        {ADR_CTRL,   8'hC0, 8'h00},  // bits 7:6 read zero
        {ADR_FLAGS,  8'hFF, 8'h00},  // R9: writing ones has no effect
        {ADR_CNT_LO, 8'h78, 8'h78},
        {ADR_CNT_HI, 8'h56, 8'h00}   // R3: high read returns stale latch
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(ADR_CNT_LO, lo);
        rd(ADR_CNT_HI, hi);
        v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic pulse_a();
        @(negedge clk); pin_a = 1'b1;
        @(negedge clk); pin_a = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_b();
        @(negedge clk); pin_b = 1'b1;
        @(negedge clk); pin_b = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog got=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), b);
            chk("R1 reg", b, 8'h00);
        end
        chk("R1 pwm_out", pwm_out, 1'b0);
        chk("R1 irq", {irq_a, irq_b}, 2'b00);

        // R2 register table
        for (int i = 0; i < 9; i++) begin
            wr(REG_VEC[i][18:16], REG_VEC[i][15:8]);
            rd(REG_VEC[i][18:16], b);
            chk("R2 table", b, REG_VEC[i][7:0]);
        end
        rd16(v);
        chk("R3 lo then hi", v, 16'h5678);

        // R5 PWM setup, stopped
        wr(ADR_RA_LO, 8'd2); wr(ADR_RA_HI, 8'd0);
        wr(ADR_RB_LO, 8'd3); wr(ADR_RB_HI, 8'd0);
        wr(ADR_CNT_LO, 8'd1); wr(ADR_CNT_HI, 8'd0);
        ticks(2);
        rd16(v);
        chk("R4 run off holds", v, 16'd1);
        wr(ADR_CTRL, 8'h04);
        ticks(2);
        rd16(v);
        chk("R5 first uflow loads B", v, 16'd3);
        chk("R5 pwm high", pwm_out, 1'b1);
        rd(ADR_FLAGS, b);
        chk("R5 pend A", b, 8'h01);
        chk("R10 irq_a off when disabled", irq_a, 1'b0);
        wr(ADR_CTRL, 8'h14);
        chk("R10 irq_a on", irq_a, 1'b1);
        ticks(4);
        rd16(v);
        chk("R5 second uflow loads A", v, 16'd2);
        chk("R5 pwm low", pwm_out, 1'b0);
        rd(ADR_FLAGS, b);
        chk("R5 pend B", b, 8'h03);

        // R9 clear
        wr(ADR_FLAGS, 8'h02);
        rd(ADR_FLAGS, b);
        chk("R9 clear A keep B", b, 8'h02);
        wr(ADR_FLAGS, 8'h00);
        rd(ADR_FLAGS, b);
        chk("R9 clear all", b, 8'h00);

        // R11 write during tick
        @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = ADR_CNT_LO; wdata = 8'h09;
        @(negedge clk); tick = 1'b0; wr_en = 1'b0;
        rd16(v);
        chk("R11 write beats tick", v, 16'h0009);

        // R6 event mode
        wr(ADR_CTRL, 8'h01);
        wr(ADR_CNT_LO, 8'd1);
        wr(ADR_RA_LO, 8'd4);
        wr(ADR_CTRL, 8'h05);
        ticks(3);
        rd16(v);
        chk("R6 tick ignored", v, 16'd1);
        pulse_a();
        rd16(v);
        chk("R6 edge decrements", v, 16'd0);
        pulse_a();
        rd16(v);
        chk("R6 uflow reloads A", v, 16'd4);
        rd(ADR_FLAGS, b);
        chk("R6 pend A", b, 8'h01);
        wr(ADR_CTRL, 8'h0D);
        @(negedge clk); pin_a = 1'b1;
        @(negedge clk);
        rd16(v);
        chk("R6 falling select ignores rise", v, 16'd4);
        pin_a = 1'b0;
        @(negedge clk);
        rd16(v);
        chk("R6 falling edge counts", v, 16'd3);

        // R7 pin B in event mode
        wr(ADR_FLAGS, 8'h00);
        pulse_b();
        rd(ADR_FLAGS, b);
        chk("R7 pin B gated off", b, 8'h00);
        wr(ADR_CTRL, 8'h2D);
        pulse_b();
        rd(ADR_FLAGS, b);
        chk("R7 pin B sets pend B", b, 8'h02);
        chk("R10 irq_b", irq_b, 1'b1);

        // R8 capture mode
        wr(ADR_CTRL, 8'h02);
        wr(ADR_FLAGS, 8'h00);
        wr(ADR_CNT_LO, 8'd5); wr(ADR_CNT_HI, 8'd0);
        wr(ADR_CTRL, 8'h06);
        ticks(3);
        pulse_a();
        rd(ADR_RA_LO, b); v[7:0] = b;
        rd(ADR_RA_HI, b); v[15:8] = b;
        chk("R8 capture A", v, 16'd2);
        ticks(3);
        rd16(v);
        chk("R8 wrap", v, 16'hFFFF);
        pulse_b();
        rd(ADR_RB_LO, b); v[7:0] = b;
        rd(ADR_RB_HI, b); v[15:8] = b;
        chk("R8 capture B", v, 16'hFFFF);
        rd(ADR_FLAGS, b);
        chk("R8 pends", b, 8'h03);

        // R9 set wins over clear in same cycle
        wr(ADR_FLAGS, 8'h00);
        @(negedge clk); pin_a = 1'b1; wr_en = 1'b1; addr = ADR_FLAGS; wdata = 8'h00;
        @(negedge clk); pin_a = 1'b0; wr_en = 1'b0;
        rd(ADR_FLAGS, b);
        chk("R9 set beats clear", b, 8'h01);

        // R3 coherent latch while running
        wr(ADR_CTRL, 8'h02);
        wr(ADR_CNT_LO, 8'h00); wr(ADR_CNT_HI, 8'h01);
        rd(ADR_CNT_LO, b);
        chk("R3 lo", b, 8'h00);
        wr(ADR_CTRL, 8'h06);
        ticks(1);
        rd(ADR_CNT_HI, b);
        chk("R3 latched hi", b, 8'h01);

        // R4 halted mode code
        wr(ADR_CTRL, 8'h07);
        ticks(2);
        rd16(v);
        chk("R4 mode 11 holds", v, 16'h00FF);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule